// File: doc/BRIEF.md
# S-FSK Carrier Tone Synthesizer

This block turns a stream of transmit bits into digital sine samples for a spread-FSK power-line transmitter. Two carrier frequencies are programmed as codes in 10 Hz units. A zero bit is sent on the space tone and a one bit on the mark tone. A 32-bit phase accumulator advances by a per-tone increment derived from the code. The top bits of the accumulator address a quarter-wave sine table, and mirroring rebuilds the full period from it.

A frame starts on a bit strobe while transmit is enabled. The block then takes one new bit per strobe and changes tone without a phase jump. After the last bit of a fixed-length frame it keeps the line-driver enable asserted for one more bit period, measured from the strobe cadence, and then drops it. The block also presents the plain level of the bit on air and a flag for an illegal tone configuration. A sigma-delta converter and analog filtering sit downstream and are not part of this block.

Top module: `sfsk_tone_gen`

## Requirements
- R1: While a frame is active, the accumulator advances each cycle by the space increment when the current bit is 0 and by the mark increment when it is 1.
- R2: The increment for a code c is (c × K + 2^15) >> 16 (32 bits), with K = round(10 × 2^48 / CLK_HZ), so one code step is 10 Hz. It is registered one cycle after the code inputs.
- R3: `cfg_bad_o` is 1 one cycle after either code lies outside 900..9500 (9 kHz to 95 kHz) or the two codes differ by less than 1000 (10 kHz). It resets to 1. A start strobe seen while it is 1 does not start a frame.
- R4: `tx_data_o` equals the bit currently on air while a frame is active, and is 0 otherwise.
- R5: `tx_active_o` rises at the edge after an accepted start strobe. It falls P cycles after the edge that samples the 288th strobe, where P is the number of cycles between the last two strobes.
- R6: The accumulator is 0 at the first active cycle and is never reset or reloaded at a tone change.
- R7: `sample_o` is registered. It equals round(2047 × sin(2π(n + 0.5)/1024)) (±1 LSB), where n is the top 10 bits of the accumulator in the previous cycle, if the block was active in that cycle. Otherwise it is 0.
- R8: Strobes sampled during the closing bit period are ignored, including one that lands on the edge where the period expires.
- R9: Dropping `tx_en` during a frame ends it at the next edge.
- R10: A strobe with `tx_en` low does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| space_code | input | 14 | Space tone frequency in 10 Hz units |
| mark_code | input | 14 | Mark tone frequency in 10 Hz units |
| tx_en | input | 1 | Transmit enable |
| bit_stb | input | 1 | One-cycle strobe presenting a new bit |
| bit_in | input | 1 | Bit value sampled with the strobe |
| sample_o | output | 12 | Signed sine sample |
| tx_active_o | output | 1 | Line-driver enable |
| tx_data_o | output | 1 | Unmodulated level of the bit on air |
| cfg_bad_o | output | 1 | Illegal tone configuration flag |

## Verification
The risky coincidence is the end of the closing bit period arriving in the same cycle as a strobe. With a steady strobe cadence, the strobe after the last frame bit lands exactly on the expiry edge. The bench keeps strobing past the frame end, so this always happens, and it expects `tx_active_o` to fall with no new frame and `tx_data_o` at 0. Only the strobe one period later may start the next frame. Tone changes coinciding with every strobe are judged sample by sample against an arithmetic accumulator and sine model that never resets phase at a bit boundary.

// File: rtl/sfsk_pkg.sv
package sfsk_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_TAIL = 2'd2
   } tx_state_e;

   // pi/2 in Q30
   localparam longint HALF_PI_Q30 = 64'sd1686629713;
   localparam longint ONE_Q30     = 64'sd1073741824;

   // Sine of the centre of quarter-wave slot idx, scaled to amp, Horner-form series.
   function automatic int quarter_sine(input int idx, input int aw, input int amp);
      longint x, x2, t, s, v;
      x  = (longint'(2 * idx + 1) * HALF_PI_Q30) >>> (aw + 1);
      x2 = (x * x) >>> 30;
      t  = ONE_Q30 - x2 / 72;
      t  = ONE_Q30 - ((x2 * t) >>> 30) / 42;
      t  = ONE_Q30 - ((x2 * t) >>> 30) / 20;
      t  = ONE_Q30 - ((x2 * t) >>> 30) / 6;
      s  = (x * t) >>> 30;
      v  = (s * longint'(amp) + (64'sd1 <<< 29)) >>> 30;
      return int'(v);
   endfunction

endpackage

// File: rtl/sfsk_inc_calc.sv
module sfsk_inc_calc #(
   parameter int     FREQ_W   = 14,
   parameter int     PHASE_W  = 32,
   parameter longint CLK_HZ   = 24000000,
   parameter int     MIN_CODE = 900,
   parameter int     MAX_CODE = 9500,
   parameter int     SEP_CODE = 1000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FREQ_W-1:0]  space_code,
   input  logic [FREQ_W-1:0]  mark_code,
   output logic [PHASE_W-1:0] space_inc,
   output logic [PHASE_W-1:0] mark_inc,
   output logic               cfg_bad
);
   localparam int     FRAC_W = 16;
   localparam longint STEP_K = ((64'sd10 <<< (PHASE_W + FRAC_W)) + CLK_HZ / 2) / CLK_HZ;
   localparam longint HALF_U = 64'sd1 <<< (FRAC_W - 1);

   if (FREQ_W < 1 || FREQ_W > 24) begin : g_bad_fw
      $error("FREQ_W out of supported range");
   end
   if (PHASE_W < 8 || PHASE_W > 40) begin : g_bad_pw
      $error("PHASE_W out of supported range");
   end
   if (MIN_CODE > MAX_CODE) begin : g_bad_rng
      $error("MIN_CODE above MAX_CODE");
   end

   function automatic logic [PHASE_W-1:0] code_to_inc(input logic [FREQ_W-1:0] c);
      longint p;
      p = (longint'(c) * STEP_K + HALF_U) >>> FRAC_W;
      return p[PHASE_W-1:0];
   endfunction

   logic        out_rng;
   logic        too_close;
   int unsigned diff;

   always_comb begin
      out_rng = (int'(space_code) < MIN_CODE) || (int'(space_code) > MAX_CODE) ||
                (int'(mark_code)  < MIN_CODE) || (int'(mark_code)  > MAX_CODE);
      diff    = (space_code > mark_code) ? int'(space_code - mark_code)
                                         : int'(mark_code - space_code);
      too_close = diff < SEP_CODE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         space_inc <= '0;
         mark_inc  <= '0;
         cfg_bad   <= 1'b1;
      end else begin
         space_inc <= code_to_inc(space_code);
         mark_inc  <= code_to_inc(mark_code);
         cfg_bad   <= out_rng || too_close;
      end
   end

endmodule

// File: rtl/sfsk_sine_rom.sv
module sfsk_sine_rom
   import sfsk_pkg::*;
#(
   parameter int LUT_AW = 8,
   parameter int SAMP_W = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic [LUT_AW+1:0]        phase_top,
   output logic signed [SAMP_W-1:0] sample
);
   localparam int QSIZE = 1 << LUT_AW;
   localparam int AMP   = (1 << (SAMP_W - 1)) - 1;

   if (LUT_AW < 2 || LUT_AW > 11) begin : g_bad_aw
      $error("LUT_AW out of supported range");
   end
   if (SAMP_W < 4 || SAMP_W > 16) begin : g_bad_sw
      $error("SAMP_W out of supported range");
   end

   logic signed [SAMP_W-1:0] lut [QSIZE];

   for (genvar g = 0; g < QSIZE; g++) begin : g_lut
      localparam int VAL = quarter_sine(g, LUT_AW, AMP);
      assign lut[g] = SAMP_W'(VAL);
   end

   logic [1:0]               quad;
   logic [LUT_AW-1:0]        idx;
   logic [LUT_AW-1:0]        ridx;
   logic signed [SAMP_W-1:0] mag;
   logic signed [SAMP_W-1:0] val;

   always_comb begin
      quad = phase_top[LUT_AW+1:LUT_AW];
      idx  = phase_top[LUT_AW-1:0];
      ridx = quad[0] ? ~idx : idx;
      mag  = lut[ridx];
      val  = quad[1] ? -mag : mag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sample <= '0;
      else        sample <= en ? val : '0;
   end

   // R7
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (sample == '0));

endmodule

// File: rtl/sfsk_tx_seq.sv
module sfsk_tx_seq
   import sfsk_pkg::*;
#(
   parameter int FRAME_BITS = 288,
   parameter int PER_W      = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic bit_stb,
   input  logic bit_in,
   input  logic cfg_bad,
   output logic run,
   output logic cur_bit,
   output logic tx_data
);
   localparam int BC_W = $clog2(FRAME_BITS + 1);

   if (FRAME_BITS < 2) begin : g_bad_fb
      $error("FRAME_BITS must be at least 2");
   end
   if (PER_W < 2 || PER_W > 31) begin : g_bad_pw
      $error("PER_W out of supported range");
   end

   tx_state_e        st_q, st_d;
   logic             bit_d;
   logic [BC_W-1:0]  bc_q, bc_d;
   logic [PER_W-1:0] gap_q;
   logic [PER_W-1:0] tcnt_q, tcnt_d;
   logic             last_stb;

   assign last_stb = (int'(bc_q) == FRAME_BITS - 1);

   always_comb begin
      st_d   = st_q;
      bit_d  = cur_bit;
      bc_d   = bc_q;
      tcnt_d = tcnt_q;
      unique case (st_q)
         ST_IDLE: begin
            if (tx_en && bit_stb && !cfg_bad) begin
               st_d  = ST_SEND;
               bit_d = bit_in;
               bc_d  = BC_W'(1);
            end
         end
         ST_SEND: begin
            if (!tx_en) begin
               st_d = ST_IDLE;
            end else if (bit_stb) begin
               bit_d = bit_in;
               bc_d  = bc_q + BC_W'(1);
               if (last_stb) begin
                  st_d   = ST_TAIL;
                  tcnt_d = gap_q;
               end
            end
         end
         ST_TAIL: begin
            if (!tx_en || tcnt_q == '0) st_d = ST_IDLE;
            else                        tcnt_d = tcnt_q - PER_W'(1);
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cur_bit <= 1'b0;
         bc_q    <= '0;
         gap_q   <= '0;
         tcnt_q  <= '0;
         run     <= 1'b0;
         tx_data <= 1'b0;
      end else begin
         st_q    <= st_d;
         cur_bit <= bit_d;
         bc_q    <= bc_d;
         tcnt_q  <= tcnt_d;
         run     <= (st_d != ST_IDLE);
         tx_data <= (st_d != ST_IDLE) && bit_d;
         if (bit_stb)            gap_q <= '0;
         else if (~&gap_q)       gap_q <= gap_q + PER_W'(1);
      end
   end

   // R3
   bad_cfg_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && tx_en && bit_stb && cfg_bad) |=> !run);

   // R10
   no_en_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && !tx_en) |=> !run);

   // R5
   tail_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TAIL && tcnt_q == '0) |=> !run);

   // R8
   tail_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TAIL && bit_stb) |=> $stable(cur_bit));

   // R9
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE && !tx_en) |=> !run);

   // R4
   data_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_data |-> (run && cur_bit));

endmodule

// File: rtl/sfsk_tone_gen.sv
module sfsk_tone_gen #(
   parameter int     FREQ_W     = 14,
   parameter int     PHASE_W    = 32,
   parameter int     LUT_AW     = 8,
   parameter int     SAMP_W     = 12,
   parameter longint CLK_HZ     = 24000000,
   parameter int     MIN_CODE   = 900,
   parameter int     MAX_CODE   = 9500,
   parameter int     SEP_CODE   = 1000,
   parameter int     FRAME_BITS = 288,
   parameter int     PER_W      = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [FREQ_W-1:0]        space_code,
   input  logic [FREQ_W-1:0]        mark_code,
   input  logic                     tx_en,
   input  logic                     bit_stb,
   input  logic                     bit_in,
   output logic signed [SAMP_W-1:0] sample_o,
   output logic                     tx_active_o,
   output logic                     tx_data_o,
   output logic                     cfg_bad_o
);
   localparam int TOP_W = LUT_AW + 2;

   if (PHASE_W < TOP_W) begin : g_bad_top
      $error("PHASE_W too narrow for the sine table address");
   end

   logic [PHASE_W-1:0] space_inc, mark_inc, step;
   logic [PHASE_W-1:0] acc_q;
   logic               run, cur_bit;

   sfsk_inc_calc #(
      .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .CLK_HZ(CLK_HZ),
      .MIN_CODE(MIN_CODE), .MAX_CODE(MAX_CODE), .SEP_CODE(SEP_CODE)
   ) inc_i (
      .clk(clk), .rst_n(rst_n),
      .space_code(space_code), .mark_code(mark_code),
      .space_inc(space_inc), .mark_inc(mark_inc), .cfg_bad(cfg_bad_o)
   );

   sfsk_tx_seq #(
      .FRAME_BITS(FRAME_BITS), .PER_W(PER_W)
   ) seq_i (
      .clk(clk), .rst_n(rst_n),
      .tx_en(tx_en), .bit_stb(bit_stb), .bit_in(bit_in), .cfg_bad(cfg_bad_o),
      .run(run), .cur_bit(cur_bit), .tx_data(tx_data_o)
   );

   assign step = cur_bit ? mark_inc : space_inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= '0;
      else if (run) acc_q <= acc_q + step;
      else          acc_q <= '0;
   end

   sfsk_sine_rom #(
      .LUT_AW(LUT_AW), .SAMP_W(SAMP_W)
   ) rom_i (
      .clk(clk), .rst_n(rst_n), .en(run),
      .phase_top(acc_q[PHASE_W-1 -: TOP_W]),
      .sample(sample_o)
   );

   assign tx_active_o = run;

   // R6
   phase_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> (acc_q == $past(acc_q) + $past(cur_bit ? mark_inc : space_inc)));

   // R6
   phase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (acc_q == '0));

endmodule

// File: tb/sfsk_tone_gen_tb_top.sv
module sfsk_tone_gen_tb_top;
   localparam int     FREQ_W = 14;
   localparam longint CLK_HZ = 24000000;
   localparam int     FRAME  = 288;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [FREQ_W-1:0]  space_code = 14'd900;
   logic [FREQ_W-1:0]  mark_code  = 14'd9500;
   logic               tx_en = 1'b0;
   logic               bit_stb = 1'b0;
   logic               bit_in = 1'b0;
   logic signed [11:0] sample_o;
   logic               tx_active_o, tx_data_o, cfg_bad_o;

   always #2 clk = ~clk;

   sfsk_tone_gen dut_i (
      .clk(clk), .rst_n(rst_n), .space_code(space_code), .mark_code(mark_code),
      .tx_en(tx_en), .bit_stb(bit_stb), .bit_in(bit_in),
      .sample_o(sample_o), .tx_active_o(tx_active_o),
      .tx_data_o(tx_data_o), .cfg_bad_o(cfg_bad_o)
   );

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   // Arithmetic model, built from the requirement text
   localparam longint STEP_K = ((64'sd10 <<< 48) + CLK_HZ / 2) / CLK_HZ;
   int          st_m;
   bit          bit_m, bad_m, samp_on_m;
   int          bc_m, gap_m, tcnt_m;
   logic [31:0] acc_m, inc_s_m, inc_m_m, samp_ph_m;

   function automatic logic [31:0] inc_of(input int c);
      longint p;
      p = (longint'(c) * STEP_K + 64'sd32768) >>> 16;
      return p[31:0];
   endfunction

   function automatic int sine_of(input logic [31:0] ph);
      real a, v;
      a = 2.0 * 3.14159265358979 * (real'(ph[31:22]) + 0.5) / 1024.0;
      v = 2047.0 * $sin(a);
      return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         st_m = 0; bit_m = 0; bad_m = 1; samp_on_m = 0;
         bc_m = 0; gap_m = 0; tcnt_m = 0;
         acc_m = 0; inc_s_m = 0; inc_m_m = 0; samp_ph_m = 0;
      end else begin
         int s, m, d, nst;
         samp_on_m = (st_m != 0);
         samp_ph_m = acc_m;
         acc_m = (st_m != 0) ? acc_m + (bit_m ? inc_m_m : inc_s_m) : 32'd0;
         nst = st_m;
         case (st_m)
            0: if (tx_en && bit_stb && !bad_m) begin nst = 1; bit_m = bit_in; bc_m = 1; end
            1: if (!tx_en) nst = 0;
               else if (bit_stb) begin
                  bit_m = bit_in;
                  if (bc_m == FRAME - 1) begin nst = 2; tcnt_m = gap_m; end
                  bc_m++;
               end
            default: if (!tx_en || tcnt_m == 0) nst = 0; else tcnt_m--;
         endcase
         st_m = nst;
         gap_m = bit_stb ? 0 : ((gap_m < 65535) ? gap_m + 1 : gap_m);
         s = int'(space_code); m = int'(mark_code);
         d = (s > m) ? s - m : m - s;
         bad_m = (s < 900) || (s > 9500) || (m < 900) || (m > 9500) || (d < 1000);
         inc_s_m = inc_of(s);
         inc_m_m = inc_of(m);
      end
   end

   task automatic chk(input string tag, input int act, input int exp, input int tol);
      int df;
      vectors++;
      df = act - exp;
      if (df < 0) df = -df;
      if (df > tol) begin
         errors++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   string phase_tag = "reset";

   // Every cycle: compare all outputs against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk({"R5 tx_active ", phase_tag}, int'(tx_active_o), int'(st_m != 0), 0);
         chk({"R4 tx_data ", phase_tag}, int'(tx_data_o), int'(st_m != 0 && bit_m), 0);
         chk({"R3 cfg_bad ", phase_tag}, int'(cfg_bad_o), int'(bad_m), 0);
         if (samp_on_m)
            chk({"R1/R7 sample ", phase_tag}, int'(sample_o), sine_of(samp_ph_m), 1);
         else
            chk({"R7 idle sample ", phase_tag}, int'(sample_o), 0, 0);
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic strobe(input bit b, input int per);
      @(negedge clk);
      bit_stb = 1'b1; bit_in = b;
      @(negedge clk);
      bit_stb = 1'b0;
      for (int i = 0; i < per - 2; i++) @(negedge clk);
   endtask

   // Sends nbits with the given cadence; kind 0 alternating, 1 LFSR, 2 all ones
   task automatic frame(input int nbits, input int per, input int kind);
      logic [7:0] lf = 8'hA5;
      for (int i = 0; i < nbits; i++) begin
         bit b;
         case (kind)
            0: b = i[0];
            1: begin b = lf[0]; lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]}; end
            default: b = 1'b1;
         endcase
         strobe(b, per);
      end
   endtask

   initial begin
      idle(1);
      // reset state
      chk("R3 cfg_bad reset", int'(cfg_bad_o), 1, 0);
      chk("R5 tx_active reset", int'(tx_active_o), 0, 0);
      chk("R7 sample reset", int'(sample_o), 0, 0);
      idle(2);
      rst_n = 1'b1;
      idle(3);

      // R2 / R1: widest legal spread, frame then one strobe on tail expiry (R8)
      phase_tag = "frame A";
      tx_en = 1'b1;
      frame(FRAME + 1, 8, 0);
      chk("R8 strobe on tail expiry ignored", int'(tx_active_o), 0, 0);
      frame(2, 8, 1);
      phase_tag = "frame A2 abort";
      tx_en = 1'b0;           // R9: abort mid-frame
      idle(2);
      chk("R9 abort", int'(tx_active_o), 0, 0);

      // R10: strobe without enable
      phase_tag = "no enable";
      frame(3, 4, 2);
      chk("R10 no start without tx_en", int'(tx_active_o), 0, 0);

      // R3: separation just under the limit, then out of range
      phase_tag = "bad cfg";
      space_code = 14'd6300; mark_code = 14'd5301;
      idle(2);
      chk("R3 separation 999 flagged", int'(cfg_bad_o), 1, 0);
      tx_en = 1'b1;
      frame(3, 4, 2);
      chk("R3 start refused", int'(tx_active_o), 0, 0);
      tx_en = 1'b0;
      space_code = 14'd899; mark_code = 14'd5000;
      idle(2);
      chk("R3 below 9 kHz flagged", int'(cfg_bad_o), 1, 0);
      space_code = 14'd5000; mark_code = 14'd9501;
      idle(2);
      chk("R3 above 95 kHz flagged", int'(cfg_bad_o), 1, 0);

      // R6 / R1: exact 10 kHz separation, mark below space, LFSR bits
      phase_tag = "frame B";
      space_code = 14'd6300; mark_code = 14'd5300;
      idle(2);
      chk("R3 separation 1000 accepted", int'(cfg_bad_o), 0, 0);
      tx_en = 1'b1;
      frame(FRAME, 5, 1);
      idle(8);
      chk("R5 enable dropped after tail", int'(tx_active_o), 0, 0);

      // R5: uneven cadence, the last interval sets the tail
      phase_tag = "frame C";
      space_code = 14'd1234; mark_code = 14'd8765;
      idle(2);
      frame(FRAME - 1, 3, 0);
      strobe(1'b1, 11);
      idle(12);
      tx_en = 1'b0;
      idle(4);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 100000; i++) @(posedge clk);
      done = 1;
      errors++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule